// File: doc/BRIEF.md
# Asynchronous External Bus Master

This block runs read and write cycles on an asynchronous, non-multiplexed external bus for a processor core. The core gives it a byte address, a direction, an operand size and the write data. The block then drives a 24-bit address, an address strobe, a data strobe, a read/write line and two size lines onto the bus. On writes it also drives a 16-bit data bus. It ends the cycle when the addressed device returns an acknowledge. Read data goes back to the core with a one-tick done pulse.

Strobe edges fall on half bus-clock boundaries. The block is clocked by `clk_i` at twice the bus-clock rate, and each `clk_i` period is one half bus clock (one "tick"). An internal phase bit produces the bus clock `bclk_o`. A cycle may begin only on a rising edge of `bclk_o`. The acknowledge input is treated as asynchronous and passes through a parameterised synchroniser, so each extra stage adds latency before the cycle can end. A single cycle moves 8 or 16 bits; splitting wider operands is left to the core.

Top module: `ebm_bus_master`

## Requirements
- R1: While reset is held and after it ends, `as_n_o` and `ds_n_o` are high, `rw_o` is high, `drive_o` is low (data bus released) and `done_o` is low.
- R2: The address, size and read/write outputs are set when a cycle begins and stay stable for as long as `as_n_o` is low. The address equals the byte address of the request.
- R3: A cycle begins on a rising edge of `bclk_o`. `as_n_o` falls exactly one tick later, which is a falling edge of `bclk_o`.
- R4: On a read (`rw_o` = 1), `ds_n_o` falls in the same tick as `as_n_o`.
- R5: On a write (`rw_o` = 0), `drive_o` rises one tick after `as_n_o` falls. From then on all 16 data lines carry the request's write data, whatever the operand size.
- R6: On a write, `ds_n_o` stays high for two ticks after `as_n_o` falls and goes low in the third tick, one full bus clock after the address strobe.
- R7: The synchronised acknowledge is examined on rising bus-clock edges, starting one full clock after `as_n_o` falls. Each examination that finds it negated adds one full bus-clock wait state. Two ticks after the examination that finds it asserted, both strobes go high. If `ack_n_i` goes low k ticks after `as_n_o` falls, with S synchroniser stages, then `as_n_o` stays low for c+2 ticks, where c is max(2, k+S) rounded up to an even number.
- R8: On a read, the data bus is captured on the last falling edge of `bclk_o` in the cycle. The captured value is presented on `rdata_o` while `done_o` is high.
- R9: `rw_o` changes only while `as_n_o` is high and only when a new cycle's direction differs from the previous cycle's. It stays low across back-to-back writes and high across back-to-back reads.
- R10: `siz_o` is 2'b01 for a one-byte transfer (`word_i` = 0) and 2'b10 for a two-byte transfer (`word_i` = 1).
- R11: `done_o` is high for exactly one tick, the tick in which both strobes have just returned high. In the next tick `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Double-rate clock; one period is half a bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Core request; held until `done_o` |
| wr_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = two-byte transfer, 0 = one byte |
| addr_i | input | 24 | Byte address (most significant byte for two bytes) |
| wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-tick end-of-cycle pulse |
| rdata_o | output | 16 | Captured read data |
| bclk_o | output | 1 | Bus clock |
| addr_o | output | 24 | Bus address |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| siz_o | output | 2 | Bytes still to move in the operand |
| data_io | inout | 16 | Bidirectional data bus |
| drive_o | output | 1 | High while the block drives `data_io` |
| ack_n_i | input | 1 | Asynchronous acknowledge, active low |

## Verification
The bench goes after the strobe offsets of reads against writes. A design that shares one data-strobe schedule for both directions would assert the write strobe with the address strobe, before the data is on the bus. It counts address-strobe length against the acknowledge delay, so an off-by-one in the synchroniser or wait loop shows up as a cycle that ends a tick early or late. Runs of same-direction cycles catch a read/write line that pulses between cycles. The bench also checks the released bus after each cycle and the read value at done, which together catch data captured on the wrong edge or driven too long.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_W1, ST_W2, ST_S4, ST_S5
  } ebm_state_e;

  // size code: bytes remaining in the operand
  function automatic logic [1:0] siz_code(input logic word);
    return word ? 2'b10 : 2'b01;
  endfunction

  function automatic logic as_on(input ebm_state_e st);
    return (st == ST_S1) || (st == ST_S2) || (st == ST_S3) ||
           (st == ST_W1) || (st == ST_W2) || (st == ST_S4);
  endfunction

  // reads strobe with the address, writes one full clock later
  function automatic logic ds_on(input ebm_state_e st, input logic wr);
    logic late;
    late = (st == ST_S3) || (st == ST_W1) || (st == ST_W2) || (st == ST_S4);
    return wr ? late : (late || st == ST_S1 || st == ST_S2);
  endfunction

  // write data appears half a clock after the address strobe, held through S5
  function automatic logic drive_on(input ebm_state_e st, input logic wr);
    return wr && ((st == ST_S2) || (st == ST_S3) || (st == ST_W1) ||
                  (st == ST_W2) || (st == ST_S4) || (st == ST_S5));
  endfunction

  // ticks where the synchronised acknowledge is examined
  function automatic logic ack_point(input ebm_state_e st);
    return (st == ST_S3) || (st == ST_W2);
  endfunction

endpackage

// File: rtl/ebm_ack_sync.sv
module ebm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ack_n_i,
  output logic ack_n_o
);
  generate
    if (STAGES == 0) begin : g_pass
      assign ack_n_o = ack_n_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      for (genvar g = 0; g < STAGES; g++) begin : g_st
        if (g == 0) begin : g_first
          always_ff @(posedge clk_i) begin
            if (rst_i) sh[g] <= 1'b1;
            else       sh[g] <= ack_n_i;
          end
        end else begin : g_next
          always_ff @(posedge clk_i) begin
            if (rst_i) sh[g] <= 1'b1;
            else       sh[g] <= sh[g-1];
          end
        end
      end
      assign ack_n_o = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ebm_seq.sv
module ebm_seq
  import ebm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       req_i,
  input  logic       ack_s_i,   // synchronised acknowledge, active high
  output ebm_state_e st_o,
  output logic       ph_o,      // bus clock level
  output logic       start_o,   // IDLE -> S0 this edge
  output logic       ack_seen_o,
  output logic       cap_o      // S4 -> S5 edge (last falling edge)
);
  ebm_state_e st_q, st_d;
  logic       ph_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) ph_q <= 1'b0;
    else       ph_q <= ~ph_q;
  end

  assign start_o    = (st_q == ST_IDLE) && req_i && !ph_q;
  assign ack_seen_o = ack_point(st_q) && ack_s_i;
  assign cap_o      = (st_q == ST_S4);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_o) st_d = ST_S0;
      ST_S0:   st_d = ST_S1;
      ST_S1:   st_d = ST_S2;
      ST_S2:   st_d = ST_S3;
      ST_S3:   st_d = ack_s_i ? ST_S4 : ST_W1;
      ST_W1:   st_d = ST_W2;
      ST_W2:   st_d = ack_s_i ? ST_S4 : ST_W1;
      ST_S4:   st_d = ST_S5;
      ST_S5:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) st_q <= ST_IDLE;
    else       st_q <= st_d;
  end

  assign st_o = st_q;
  assign ph_o = ph_q;
endmodule

// File: rtl/ebm_dpath.sv
module ebm_dpath
  import ebm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_in_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        siz_o,
  output logic              wr_o,
  output logic              rw_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_o  <= '0;
      wdata_o <= '0;
      siz_o   <= 2'b01;
      wr_o    <= 1'b0;
      rw_o    <= 1'b1;
    end else if (start_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      siz_o   <= siz_code(word_i);
      wr_o    <= wr_i;
      rw_o    <= ~wr_i;  // same value as before when direction repeats
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      rdata_o <= '0;
    else if (cap_i && !wr_o) rdata_o <= bus_in_i;
  end
endmodule

// File: rtl/ebm_bus_master.sv
module ebm_bus_master
  import ebm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bclk_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              as_n_o,
  output logic              ds_n_o,
  output logic              rw_o,
  output logic [1:0]        siz_o,
  inout  wire  [DATA_W-1:0] data_io,
  output logic              drive_o,
  input  logic              ack_n_i
);
  ebm_state_e       st_w;
  logic             ph_w, start_w, ack_seen_w, cap_w, ack_n_s_w, wr_w;
  logic [DATA_W-1:0] wdata_w;

  ebm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .ack_n_i(ack_n_i), .ack_n_o(ack_n_s_w)
  );

  ebm_seq u_seq (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .ack_s_i(~ack_n_s_w),
    .st_o(st_w), .ph_o(ph_w), .start_o(start_w),
    .ack_seen_o(ack_seen_w), .cap_o(cap_w)
  );

  ebm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_w), .cap_i(cap_w),
    .wr_i(wr_i), .word_i(word_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .bus_in_i(data_io), .addr_o(addr_o), .wdata_o(wdata_w),
    .rdata_o(rdata_o), .siz_o(siz_o), .wr_o(wr_w), .rw_o(rw_o)
  );

  assign bclk_o  = ph_w;
  assign as_n_o  = ~as_on(st_w);
  assign ds_n_o  = ~ds_on(st_w, wr_w);
  assign drive_o = drive_on(st_w, wr_w);
  assign done_o  = (st_w == ST_S5);
  assign data_io = drive_o ? wdata_w : {DATA_W{1'bz}};
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              as_n,
  input logic              ds_n,
  input logic              rw,
  input logic              bclk,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        siz,
  input logic              drive,
  input logic              done,
  input logic              ack_seen,
  input logic              cap
);
  a_r2_stable_while_as: assert property (@(posedge clk_i) disable iff (rst_i)
    (!as_n && $past(!as_n)) |-> ($stable(addr) && $stable(siz) && $stable(rw)));

  a_r3_as_on_falling: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(as_n) |-> (!bclk && $past(bclk)));

  a_r4_read_ds_with_as: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(as_n) && rw) |-> !ds_n);

  a_r5_write_drive_half: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(as_n) && !rw) |-> (!drive ##1 drive));

  a_r6_write_ds_full: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(as_n) && !rw) |-> (ds_n ##1 ds_n ##1 !ds_n));

  a_r7_end_after_ack: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(as_n) |-> $past(ack_seen, 2));

  a_r8_capture_last_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    cap |=> (!bclk && as_n));

  a_r9_rw_moves_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(rw) |-> (as_n && $past(as_n)));

  a_r10_siz_legal: assert property (@(posedge clk_i) disable iff (rst_i)
    !as_n |-> (siz == 2'b01 || siz == 2'b10));

  a_r11_done_strobes_off: assert property (@(posedge clk_i) disable iff (rst_i)
    done |-> (as_n && ds_n && $past(!as_n)));

  a_r11_release_after_done: assert property (@(posedge clk_i) disable iff (rst_i)
    done |=> (!drive && !done));
endmodule

bind ebm_bus_master ebm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .as_n(as_n_o), .ds_n(ds_n_o), .rw(rw_o),
  .bclk(bclk_o), .addr(addr_o), .siz(siz_o), .drive(drive_o), .done(done_o),
  .ack_seen(ack_seen_w), .cap(cap_w)
);

// File: tb/ebm_bus_master_tb.sv
module ebm_bus_master_tb;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr = 1'b0, word = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack_n = 1'b1;
  logic        dev_oe = 1'b0;
  logic [15:0] dev_data = '0;
  logic        done, bclk, as_n, ds_n, rw, drive;
  logic [15:0] rdata;
  logic [23:0] addr_b;
  logic [1:0]  siz;
  wire  [15:0] bus;

  int checks = 0;
  int errors = 0;
  logic prev_wr = 1'b0;  // reset leaves rw high (read)

  assign bus = dev_oe ? dev_data : 16'hzzzz;

  always #2 clk = ~clk;  // 250 MHz

  ebm_bus_master #(.SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_i(rst), .req_i(req), .wr_i(wr), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .done_o(done), .rdata_o(rdata),
    .bclk_o(bclk), .addr_o(addr_b), .as_n_o(as_n), .ds_n_o(ds_n),
    .rw_o(rw), .siz_o(siz), .data_io(bus), .drive_o(drive), .ack_n_i(ack_n)
  );

  task automatic chk(input bit ok, input string req_tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_siz(input logic w);
    return w ? 2'b10 : 2'b01;
  endfunction

  // R7 model: first examination tick c, strobe low length c+2
  function automatic int exp_as_len(input int k);
    int c;
    c = k + SYNC;
    if (c < 2) c = 2;
    if (c % 2 != 0) c = c + 1;
    return c + 2;
  endfunction

  task automatic run_cycle(input logic w, input logic wd, input logic [23:0] a,
                           input logic [15:0] d, input int k);
    int   n, t, as_len, rw_moves;
    logic rw_last, bclk_prev, as_prev, got_done;
    wr = w; word = wd; addr = a; wdata = d; req = 1'b1;
    dev_data = d ^ 16'h5a3c;
    t = -1; as_len = 0; rw_moves = 0; got_done = 1'b0;
    rw_last = rw; bclk_prev = bclk; as_prev = as_n;
    for (n = 0; n < 200 && !got_done; n++) begin
      @(negedge clk);
      if (rw !== rw_last) begin
        rw_moves++;
        chk(as_n === 1'b1, "R9 rw moved with AS low", as_n, 1);
      end
      rw_last = rw;
      if (as_n === 1'b0) begin
        if (t < 0) begin
          t = 0;
          chk(bclk === 1'b0 && bclk_prev === 1'b1 && as_prev === 1'b1,
              "R3 AS on falling bclk", {bclk_prev, bclk}, 2'b10);
          chk(rw === !w, "R9 rw level", rw, !w);
          chk(siz === exp_siz(wd), "R10 siz", siz, exp_siz(wd));
        end else t++;
        as_len++;
        chk(addr_b === a, "R2 addr", addr_b, a);
        chk(siz === exp_siz(wd), "R2 siz stable", siz, exp_siz(wd));
        if (!w) begin
          if (t == 0) chk(ds_n === 1'b0, "R4 read DS with AS", ds_n, 0);
          chk(drive === 1'b0, "R5 no drive on read", drive, 0);
          dev_oe = (ds_n === 1'b0);
        end else begin
          if (t == 0) chk(drive === 1'b0, "R5 not yet driven", drive, 0);
          if (t == 1) begin
            chk(drive === 1'b1, "R5 drive half clock", drive, 1);
            chk(bus === d, "R5 write data", bus, d);
          end
          if (t < 2) chk(ds_n === 1'b1, "R6 write DS held", ds_n, 1);
          if (t == 2) chk(ds_n === 1'b0, "R6 write DS full clock", ds_n, 0);
        end
        if (t >= k) ack_n = 1'b0;
      end
      if (done === 1'b1) begin
        got_done = 1'b1;
        chk(as_n === 1'b1 && ds_n === 1'b1, "R11 strobes off at done", {as_n, ds_n}, 2'b11);
        chk(as_len == exp_as_len(k), "R7 AS length", as_len, exp_as_len(k));
        if (!w) chk(rdata === (d ^ 16'h5a3c), "R8 read data", rdata, d ^ 16'h5a3c);
        req = 1'b0; ack_n = 1'b1; dev_oe = 1'b0;
      end
      bclk_prev = bclk; as_prev = as_n;
    end
    chk(got_done, "R7 cycle ended", got_done, 1);
    chk(rw_moves == ((w != prev_wr) ? 1 : 0), "R9 rw toggles", rw_moves, (w != prev_wr) ? 1 : 0);
    prev_wr = w;
    @(negedge clk);
    chk(drive === 1'b0 && done === 1'b0, "R11 released after done", {drive, done}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    chk(as_n === 1'b1 && ds_n === 1'b1 && rw === 1'b1 && drive === 1'b0 && done === 1'b0,
        "R1 in reset", {as_n, ds_n, rw, drive, done}, 5'b11100);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(as_n === 1'b1 && ds_n === 1'b1 && rw === 1'b1 && drive === 1'b0 && done === 1'b0,
        "R1 after reset", {as_n, ds_n, rw, drive, done}, 5'b11100);
    // directed corners
    run_cycle(1'b0, 1'b0, 24'h000001, 16'h1234, 0);  // read byte, no wait
    run_cycle(1'b0, 1'b1, 24'hfffffe, 16'hbeef, 5);  // read word, waits
    run_cycle(1'b1, 1'b1, 24'h800000, 16'hffff, 0);  // direction change
    run_cycle(1'b1, 1'b0, 24'h00a5a5, 16'h0001, 1);  // back-to-back writes
    run_cycle(1'b1, 1'b1, 24'h123456, 16'h8000, 4);
    run_cycle(1'b0, 1'b0, 24'h654321, 16'h7777, 2);  // back to read
    for (int i = 0; i < 60; i++) begin
      run_cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                24'($urandom), 16'($urandom), int'($urandom_range(0, 6)));
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule